// File: doc/BRIEF.md
# NAND Flash Host Register Front End

This block sits between a processor's simple register bus and an 8-bit NAND flash device. Software writes command, address and data bytes into registers. Each write is placed in a small write buffer, and a strobe engine turns the buffer entries one at a time into bus cycles on the NAND pins. A command entry raises the command latch line and an address entry raises the address latch line. Write cycles pulse the write strobe low and read cycles pulse the read strobe low. The low width of each strobe comes from a control register. The engine starts no cycle while the device reports busy.

To read one byte, software writes any value to a read-request register. The read goes through the same buffer. When the byte has been captured, it appears in a read register and a read-ready interrupt flag is set. Interrupt flags are cleared by writing one to them, and the interrupt output is the OR of the flags that the mask lets through.

Software can also start a page transfer:
- A page write counts the data cycles that software queues.
- A page read makes the engine issue its own read cycles.

Each page operation shows a pending bit in the status register. The bytes moved during page operations are folded into a check register. A reset register, which clears itself, clears that check register and the page byte counter.

Top module: `nand_host_regs`

## Requirements
- R1: After reset, the control register (address 0x0) reads 0x11, the status register (0x1) reads 0x11 (device ready, buffer empty), the interrupt status register (0x2) reads 0x00 and `irq` is low.
- R2: A write to 0x4 queues a command cycle (`nand_cle`=1, `nand_ale`=0). A write to 0x5 queues an address cycle (`nand_ale`=1, `nand_cle`=0). A write to 0x6 queues a data cycle (both latch lines low). Cycles run in the order they were written, and the written byte is driven on `nand_dout` with `nand_dout_en` high during the cycle.
- R3: Control bits [3:0] set the read-strobe low width and bits [7:4] set the write-strobe low width, both in clock cycles. A field value of 0 acts as 1. Each strobe pulse is followed by at least one cycle with both strobes high, and the two strobes are never low together.
- R4: The ready pin is synchronised over two flops and shown in status bit0. No cycle starts while the synchronised ready is low. Interrupt bit0 is set when the synchronised ready rises.
- R5: The write buffer holds 4 entries. Status bit1 reports full and status bit4 reports empty. A queue write (0x4 to 0x7) made while the buffer is full is dropped and sets interrupt bit1. Interrupt bit2 is set when the buffer becomes empty.
- R6: A write of any value to 0x7 queues one read cycle. When that cycle ends, the sampled byte appears at 0x8 and interrupt bit3 is set.
- R7: Writing to 0x2 clears each interrupt bit written as 1 and leaves bits written as 0 unchanged. If a bit is set and cleared in the same cycle, the set wins.
- R8: `irq` is high exactly when some bit of the interrupt status is 1 in the mask register (0x3, bits [4:0]).
- R9: Writing 1 to bit0 of 0x9 makes that bit read 1 for RST_CYC cycles (default 3), after which it reads 0. While the bit reads 1, the check register (0xB) and the page byte counter are held at zero and no new cycle starts.
- R10: Writing bit1 of the page register (0xA) sets status bit2. After PAGE_BYTES (default 8) data cycles have completed, status bit2 clears and interrupt bit4 is set.
- R11: Writing bit0 of 0xA sets status bit3. The engine then issues PAGE_BYTES read cycles by itself, after which status bit3 clears. These reads do not touch 0x8 or interrupt bit3.
- R12: Register 0xB holds the XOR of every byte moved during page operations since the last reset. A page start is ignored while a page operation is pending. If bits 0 and 1 are written together, only the page read starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe of the access |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| irq | output | 1 | Masked interrupt request |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dout | output | 8 | Data driven to the device |
| nand_dout_en | output | 1 | Output enable for nand_dout |
| nand_din | input | 8 | Data from the device |
| nand_rdy | input | 1 | Device ready (high) / busy (low) |

## Verification
Queue writes are tried in several ways:
- Directed command/address/data mixes, which separate the three latch-line encodings.
- A random run with random strobe widths and random entry kinds, which shows both ordering and width decoding, including a zero field.

Holding the ready pin low while writing five entries separates the buffer-full, drop and overflow behaviour from the draining behaviour that follows when ready returns. Page reads and page writes are each run against a reset check register, so that the XOR value tells apart bytes counted from bytes missed. The both-bits and start-while-pending writes expose the priority rules.

// File: rtl/nand_host_pkg.sv
package nand_host_pkg;
  // Entry kind encoding equals the low two bits of the queue register address.
  typedef enum logic [1:0] {
    K_CMD  = 2'd0,
    K_ADDR = 2'd1,
    K_DATA = 2'd2,
    K_READ = 2'd3
  } kind_e;

  typedef struct packed {
    kind_e      kind;
    logic [7:0] val;
  } wb_entry_t;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_LOW  = 2'd1,
    S_HIGH = 2'd2
  } strb_st_e;

  localparam logic [3:0] A_CTRL  = 4'h0;
  localparam logic [3:0] A_STAT  = 4'h1;
  localparam logic [3:0] A_IRQ   = 4'h2;
  localparam logic [3:0] A_MASK  = 4'h3;
  localparam logic [3:0] A_RDAT  = 4'h8;
  localparam logic [3:0] A_RST   = 4'h9;
  localparam logic [3:0] A_PAGE  = 4'hA;
  localparam logic [3:0] A_ECC   = 4'hB;

  localparam int NIRQ = 5;
endpackage

// File: rtl/nand_wbuf.sv
module nand_wbuf #(
  parameter int DEPTH = 4,
  parameter int W     = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;

  function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (push_i) wp_d = wrap_inc(wp_q);
    if (pop_i)  rp_d = wrap_inc(rp_q);
    case ({push_i, pop_i})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_i) mem[wp_q] <= data_i;
  end

  assign data_o  = mem[rp_q];
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);

  // R5
  wbuf_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  // R5
  wbuf_no_push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(push_i && full_o && !pop_i));
  // R5
  wbuf_no_pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pop_i && empty_o));
endmodule

// File: rtl/nand_strobe.sv
module nand_strobe
  import nand_host_pkg::*;
#(
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DLY_W-1:0] rd_w_i,
  input  logic [DLY_W-1:0] wr_w_i,
  input  logic             rdy_i,
  input  logic             hold_i,
  input  logic             fifo_empty_i,
  input  wb_entry_t        entry_i,
  input  logic             auto_rd_i,
  input  logic [7:0]       din_i,
  output logic             pop_o,
  output logic             cle_o,
  output logic             ale_o,
  output logic             we_n_o,
  output logic             re_n_o,
  output logic [7:0]       dout_o,
  output logic             dout_en_o,
  output logic             done_o,
  output kind_e            done_kind_o,
  output logic [7:0]       done_val_o,
  output logic             done_auto_o
);
  strb_st_e         st_q, st_d;
  kind_e            kind_q, kind_d;
  logic [7:0]       val_q, val_d;
  logic             auto_q, auto_d;
  logic [DLY_W-1:0] cnt_q, cnt_d;
  logic             start;
  logic [DLY_W-1:0] width;

  assign start = (st_q == S_IDLE) && !hold_i && rdy_i && (!fifo_empty_i || auto_rd_i);
  assign pop_o = start && !fifo_empty_i;

  always_comb begin
    st_d   = st_q;
    kind_d = kind_q;
    val_d  = val_q;
    auto_d = auto_q;
    cnt_d  = cnt_q;
    width  = '0;
    case (st_q)
      S_IDLE: begin
        if (start) begin
          st_d = S_LOW;
          if (!fifo_empty_i) begin
            kind_d = entry_i.kind;
            val_d  = entry_i.val;
            auto_d = 1'b0;
          end else begin
            kind_d = K_READ;
            val_d  = '0;
            auto_d = 1'b1;
          end
          width = (kind_d == K_READ) ? rd_w_i : wr_w_i;
          cnt_d = (width == '0) ? '0 : width - 1'b1;
        end
      end
      S_LOW: begin
        if (cnt_q == '0) begin
          st_d = S_HIGH;
          if (kind_q == K_READ) val_d = din_i;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      S_HIGH:  st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      kind_q <= K_CMD;
      val_q  <= '0;
      auto_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      st_q   <= st_d;
      kind_q <= kind_d;
      val_q  <= val_d;
      auto_q <= auto_d;
      cnt_q  <= cnt_d;
    end
  end

  assign we_n_o      = !((st_q == S_LOW) && (kind_q != K_READ));
  assign re_n_o      = !((st_q == S_LOW) && (kind_q == K_READ));
  assign cle_o       = (st_q != S_IDLE) && (kind_q == K_CMD);
  assign ale_o       = (st_q != S_IDLE) && (kind_q == K_ADDR);
  assign dout_en_o   = (st_q != S_IDLE) && (kind_q != K_READ);
  assign dout_o      = val_q;
  assign done_o      = (st_q == S_HIGH);
  assign done_kind_o = kind_q;
  assign done_val_o  = val_q;
  assign done_auto_o = auto_q;

  logic any_low;
  assign any_low = !we_n_o || !re_n_o;

  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n_o && !re_n_o));
  // R2
  latch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cle_o && ale_o));
  // R4
  start_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(any_low) |-> $past(rdy_i));
  // R9
  start_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(any_low) |-> !$past(hold_i));
  // R3
  gap_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(any_low) |=> !any_low);
endmodule

// File: rtl/nand_regfile.sv
module nand_regfile
  import nand_host_pkg::*;
#(
  parameter int DLY_W      = 4,
  parameter int PAGE_BYTES = 8,
  parameter int RST_CYC    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [3:0]       bus_addr,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  input  logic             fifo_full_i,
  input  logic             fifo_empty_i,
  input  logic             rdy_i,
  input  logic             done_i,
  input  kind_e            done_kind_i,
  input  logic [7:0]       done_val_i,
  input  logic             done_auto_i,
  output logic             push_o,
  output wb_entry_t        push_entry_o,
  output logic [DLY_W-1:0] rd_w_o,
  output logic [DLY_W-1:0] wr_w_o,
  output logic             auto_rd_o,
  output logic             hold_o,
  output logic             irq_o
);
  localparam int PCW = $clog2(PAGE_BYTES + 1);
  localparam int RCW = $clog2(RST_CYC + 1);
  localparam int CTW = 2 * DLY_W;

  logic [CTW-1:0]  ctrl_q, ctrl_d;
  logic [NIRQ-1:0] irqs_q, irqs_d, set_ev, clr;
  logic [NIRQ-1:0] mask_q, mask_d;
  logic [7:0]      rdat_q, rdat_d, ecc_q, ecc_d;
  logic [RCW-1:0]  rcnt_q, rcnt_d;
  logic            pg_rd_q, pg_rd_d, pg_wr_q, pg_wr_d;
  logic [PCW-1:0]  pcnt_q, pcnt_d;
  logic            rdy_q, empty_q;

  logic wr_en, q_wr, rst_busy, pb_ev, pg_last, pg_wr_fin;

  assign wr_en    = bus_sel && bus_wr;
  assign q_wr     = wr_en && (bus_addr[3:2] == 2'b01);
  assign push_o   = q_wr && !fifo_full_i;
  assign push_entry_o.kind = kind_e'(bus_addr[1:0]);
  assign push_entry_o.val  = bus_wdata;
  assign rst_busy = (rcnt_q != '0);
  assign pb_ev    = done_i && ((pg_wr_q && (done_kind_i == K_DATA)) ||
                               (pg_rd_q && done_auto_i));
  assign pg_last  = (pcnt_q == PCW'(PAGE_BYTES - 1));
  assign pg_wr_fin = pb_ev && pg_wr_q && pg_last && !rst_busy;

  always_comb begin
    set_ev[0] = rdy_i && !rdy_q;
    set_ev[1] = q_wr && fifo_full_i;
    set_ev[2] = fifo_empty_i && !empty_q;
    set_ev[3] = done_i && (done_kind_i == K_READ) && !done_auto_i;
    set_ev[4] = pg_wr_fin;
    clr       = (wr_en && bus_addr == A_IRQ) ? bus_wdata[NIRQ-1:0] : '0;
    irqs_d    = (irqs_q & ~clr) | set_ev;
  end

  always_comb begin
    ctrl_d  = ctrl_q;
    mask_d  = mask_q;
    rdat_d  = rdat_q;
    rcnt_d  = rcnt_q;
    pg_rd_d = pg_rd_q;
    pg_wr_d = pg_wr_q;
    pcnt_d  = pcnt_q;
    ecc_d   = ecc_q;
    if (wr_en && bus_addr == A_CTRL) ctrl_d = bus_wdata[CTW-1:0];
    if (wr_en && bus_addr == A_MASK) mask_d = bus_wdata[NIRQ-1:0];
    if (set_ev[3]) rdat_d = done_val_i;
    if (wr_en && bus_addr == A_RST && bus_wdata[0]) rcnt_d = RCW'(RST_CYC);
    else if (rst_busy) rcnt_d = rcnt_q - 1'b1;
    if (rst_busy) begin
      pcnt_d = '0;
      ecc_d  = '0;
    end else if (pb_ev) begin
      ecc_d = ecc_q ^ done_val_i;
      if (pg_last) begin
        pcnt_d  = '0;
        pg_rd_d = 1'b0;
        pg_wr_d = 1'b0;
      end else begin
        pcnt_d = pcnt_q + 1'b1;
      end
    end
    if (wr_en && bus_addr == A_PAGE && !pg_rd_q && !pg_wr_q) begin
      if (bus_wdata[0]) begin
        pg_rd_d = 1'b1;
        pcnt_d  = '0;
      end else if (bus_wdata[1]) begin
        pg_wr_d = 1'b1;
        pcnt_d  = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= {{(DLY_W-1){1'b0}}, 1'b1, {(DLY_W-1){1'b0}}, 1'b1};
      irqs_q  <= '0;
      mask_q  <= '0;
      rdat_q  <= '0;
      rcnt_q  <= '0;
      pg_rd_q <= 1'b0;
      pg_wr_q <= 1'b0;
      pcnt_q  <= '0;
      ecc_q   <= '0;
      rdy_q   <= 1'b1;
      empty_q <= 1'b1;
    end else begin
      ctrl_q  <= ctrl_d;
      irqs_q  <= irqs_d;
      mask_q  <= mask_d;
      rdat_q  <= rdat_d;
      rcnt_q  <= rcnt_d;
      pg_rd_q <= pg_rd_d;
      pg_wr_q <= pg_wr_d;
      pcnt_q  <= pcnt_d;
      ecc_q   <= ecc_d;
      rdy_q   <= rdy_i;
      empty_q <= fifo_empty_i;
    end
  end

  assign rd_w_o    = ctrl_q[DLY_W-1:0];
  assign wr_w_o    = ctrl_q[CTW-1:DLY_W];
  assign auto_rd_o = pg_rd_q;
  assign hold_o    = rst_busy;
  assign irq_o     = |(irqs_q & mask_q);

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = 8'(ctrl_q);
      A_STAT:  bus_rdata = {3'b000, fifo_empty_i, pg_rd_q, pg_wr_q, fifo_full_i, rdy_i};
      A_IRQ:   bus_rdata = 8'(irqs_q);
      A_MASK:  bus_rdata = 8'(mask_q);
      A_RDAT:  bus_rdata = rdat_q;
      A_RST:   bus_rdata = {7'b0, rst_busy};
      A_PAGE:  bus_rdata = {6'b0, pg_wr_q, pg_rd_q};
      A_ECC:   bus_rdata = ecc_q;
      default: bus_rdata = '0;
    endcase
  end

  // R11 R10
  page_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pg_rd_q && pg_wr_q));
  // R6
  rd_rdy_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irqs_q[3]) |-> $past(done_i && done_kind_i == K_READ && !done_auto_i));
  // R7
  w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && bus_addr == A_IRQ && bus_wdata[3] && !set_ev[3]) |=> !irqs_q[3]);
  // R9
  rst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_busy) |-> (ecc_q == '0));
endmodule

// File: rtl/nand_host_regs.sv
module nand_host_regs
  import nand_host_pkg::*;
#(
  parameter int DEPTH      = 4,
  parameter int DLY_W      = 4,
  parameter int PAGE_BYTES = 8,
  parameter int RST_CYC    = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_sel,
  input  logic       bus_wr,
  input  logic [3:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       irq,
  output logic       nand_cle,
  output logic       nand_ale,
  output logic       nand_we_n,
  output logic       nand_re_n,
  output logic [7:0] nand_dout,
  output logic       nand_dout_en,
  input  logic [7:0] nand_din,
  input  logic       nand_rdy
);
  localparam int EW = $bits(wb_entry_t);

  logic             rdy_m, rdy_s;
  logic             push, pop, full, empty, auto_rd, hold;
  wb_entry_t        push_entry, head;
  logic [EW-1:0]    head_bits;
  logic [DLY_W-1:0] rd_w, wr_w;
  logic             done, done_auto;
  kind_e            done_kind;
  logic [7:0]       done_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_m <= 1'b1;
      rdy_s <= 1'b1;
    end else begin
      rdy_m <= nand_rdy;
      rdy_s <= rdy_m;
    end
  end

  nand_wbuf #(.DEPTH(DEPTH), .W(EW)) u_wbuf (
    .clk(clk), .rst_n(rst_n),
    .push_i(push), .data_i(push_entry),
    .pop_i(pop), .data_o(head_bits),
    .full_o(full), .empty_o(empty)
  );
  assign head = wb_entry_t'(head_bits);

  nand_strobe #(.DLY_W(DLY_W)) u_strobe (
    .clk(clk), .rst_n(rst_n),
    .rd_w_i(rd_w), .wr_w_i(wr_w),
    .rdy_i(rdy_s), .hold_i(hold),
    .fifo_empty_i(empty), .entry_i(head), .auto_rd_i(auto_rd),
    .din_i(nand_din), .pop_o(pop),
    .cle_o(nand_cle), .ale_o(nand_ale),
    .we_n_o(nand_we_n), .re_n_o(nand_re_n),
    .dout_o(nand_dout), .dout_en_o(nand_dout_en),
    .done_o(done), .done_kind_o(done_kind),
    .done_val_o(done_val), .done_auto_o(done_auto)
  );

  nand_regfile #(.DLY_W(DLY_W), .PAGE_BYTES(PAGE_BYTES), .RST_CYC(RST_CYC)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .fifo_full_i(full), .fifo_empty_i(empty), .rdy_i(rdy_s),
    .done_i(done), .done_kind_i(done_kind),
    .done_val_i(done_val), .done_auto_i(done_auto),
    .push_o(push), .push_entry_o(push_entry),
    .rd_w_o(rd_w), .wr_w_o(wr_w),
    .auto_rd_o(auto_rd), .hold_o(hold), .irq_o(irq)
  );
endmodule

// File: tb/nand_host_regs_test.sv
`timescale 1ns/1ps
module nand_host_regs_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_sel, bus_wr;
  logic [3:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic       irq, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dout_en;
  logic [7:0] nand_dout, nand_din;
  logic       nand_rdy;

  always #2 clk = ~clk;

  nand_host_regs uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dout(nand_dout),
    .nand_dout_en(nand_dout_en), .nand_din(nand_din), .nand_rdy(nand_rdy)
  );

  int nchk = 0, nerr = 0;
  bit finished = 0;

  logic [1:0] log_k [0:255];
  logic [7:0] log_v [0:255];
  int         log_w [0:255];
  int         log_n = 0;
  int         we_cnt = 0, re_cnt = 0, last_re_w = 0, rd_idx = 0;
  logic [1:0] cur_k;
  logic [7:0] cur_v;
  logic [1:0] exp_k [0:255];
  logic [7:0] exp_v [0:255];

  function automatic logic [7:0] pat(input int n);
    return (8'(n) * 8'd29) ^ 8'h3C;
  endfunction

  function automatic int eff_w(input int f);
    return (f == 0) ? 1 : f;
  endfunction

  // NAND device model and cycle monitor, sampled mid-cycle
  always @(negedge clk) begin
    if (rst_n) begin
      if (!nand_we_n) begin
        we_cnt = we_cnt + 1;
        cur_k  = {nand_cle, nand_ale};
        cur_v  = nand_dout;
      end else if (we_cnt != 0) begin
        log_k[log_n] = cur_k;
        log_v[log_n] = cur_v;
        log_w[log_n] = we_cnt;
        log_n  = log_n + 1;
        we_cnt = 0;
      end
      if (!nand_re_n) begin
        if (re_cnt == 0) begin
          rd_idx   = rd_idx + 1;
          nand_din = pat(rd_idx);
        end
        re_cnt = re_cnt + 1;
      end else if (re_cnt != 0) begin
        last_re_w = re_cnt;
        re_cnt    = 0;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain();
    logic [7:0] s;
    do rd(4'h1, s); while (s[4] == 1'b0);
    idle(40);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nerr++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, x;
    int base, n, rw, ww, k0;
    void'($urandom(32'd1234));
    bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    nand_rdy = 1; nand_din = 0; rst_n = 0;
    idle(4);
    rst_n = 1;
    idle(4);

    // R1 reset state
    rd(4'h0, v); chk("R1 ctrl", v, 8'h11);
    rd(4'h1, v); chk("R1 status", v, 8'h11);
    rd(4'h2, v); chk("R1 irqstat", v, 8'h00);
    chk("R1 irq", irq, 1'b0);

    // R2 directed cmd/addr/data
    base = log_n;
    wr(4'h4, 8'h70); wr(4'h5, 8'h12); wr(4'h6, 8'hA5);
    drain();
    chk("R2 count", log_n - base, 3);
    chk("R2 cmd", {log_k[base], log_v[base]}, {2'b10, 8'h70});
    chk("R2 addr", {log_k[base+1], log_v[base+1]}, {2'b01, 8'h12});
    chk("R2 data", {log_k[base+2], log_v[base+2]}, {2'b00, 8'hA5});
    chk("R3 default width", log_w[base], 1);

    // R3 widths, write 5, read 3, then zero fields
    wr(4'h0, 8'h53);
    base = log_n;
    wr(4'h6, 8'h01); wr(4'h7, 8'h00);
    drain();
    chk("R3 write width 5", log_w[base], 5);
    chk("R3 read width 3", last_re_w, 3);
    wr(4'h0, 8'h00);
    base = log_n;
    wr(4'h6, 8'h02); wr(4'h7, 8'h00);
    drain();
    chk("R3 zero write field", log_w[base], 1);
    chk("R3 zero read field", last_re_w, 1);
    wr(4'h2, 8'h1F);

    // R6 single read and R7 write-one-to-clear
    k0 = rd_idx;
    wr(4'h7, 8'h99);
    drain();
    rd(4'h8, v); chk("R6 read byte", v, pat(k0 + 1));
    rd(4'h2, v); chk("R6 rd ready", v[3], 1'b1);
    wr(4'h2, 8'h00);
    rd(4'h2, v); chk("R7 write zero keeps", v[3], 1'b1);
    wr(4'h2, 8'h08);
    rd(4'h2, v); chk("R7 write one clears", v[3], 1'b0);
    chk("R7 other bit kept", v[2], 1'b1);
    wr(4'h2, 8'h1F);

    // R4 / R5 busy, full, overflow
    nand_rdy = 0;
    idle(4);
    rd(4'h1, v); chk("R4 status busy", v[0], 1'b0);
    base = log_n;
    for (int i = 0; i < 5; i++) wr(4'h6, 8'hC0 + 8'(i));
    idle(20);
    chk("R4 no cycle when busy", log_n - base, 0);
    rd(4'h1, v); chk("R5 full", v[1], 1'b1);
    rd(4'h2, v); chk("R5 overflow", v[1], 1'b1);
    chk("R4 no notbusy yet", v[0], 1'b0);
    nand_rdy = 1;
    drain();
    chk("R5 dropped fifth", log_n - base, 4);
    chk("R5 order kept", log_v[base+3], 8'hC3);
    rd(4'h2, v);
    chk("R4 notbusy irq", v[0], 1'b1);
    chk("R5 edge irq", v[2], 1'b1);

    // R8 masking
    wr(4'h3, 8'h00); idle(1);
    chk("R8 masked", irq, 1'b0);
    wr(4'h3, 8'h04); idle(1);
    chk("R8 unmasked", irq, 1'b1);
    wr(4'h2, 8'h1F); idle(1);
    chk("R8 cleared", irq, 1'b0);

    // R2 / R3 random mix
    rw = $urandom % 16; ww = $urandom % 16;
    wr(4'h0, {4'(ww), 4'(rw)});
    base = log_n; n = 0;
    for (int i = 0; i < 30; i++) begin
      int kk;
      kk = $urandom % 3;
      v  = 8'($urandom);
      do rd(4'h1, x); while (x[1] == 1'b1);
      wr(4'h4 + 4'(kk), v);
      exp_k[n] = (kk == 0) ? 2'b10 : (kk == 1) ? 2'b01 : 2'b00;
      exp_v[n] = v;
      n++;
    end
    drain();
    chk("R2 random count", log_n - base, n);
    for (int i = 0; i < n; i++)
      chk("R2 random entry", {log_k[base+i], log_v[base+i]}, {exp_k[i], exp_v[i]});
    chk("R3 random width", log_w[base], eff_w(ww));
    wr(4'h0, 8'h11);

    // R9 self-clearing reset
    wr(4'h9, 8'h01);
    rd(4'h9, v); chk("R9 busy", v[0], 1'b1);
    idle(6);
    rd(4'h9, v); chk("R9 self clear", v[0], 1'b0);
    rd(4'hB, v); chk("R9 check cleared", v, 8'h00);

    // R10 page write
    wr(4'h2, 8'h1F);
    wr(4'hA, 8'h02);
    rd(4'h1, v); chk("R10 pending", v[2], 1'b1);
    wr(4'hA, 8'h01);
    rd(4'h1, v); chk("R12 start ignored", v[3], 1'b0);
    x = 8'h00;
    for (int i = 0; i < 8; i++) begin
      v = 8'($urandom);
      x = x ^ v;
      do rd(4'h1, bus_wdata); while (bus_rdata[1] == 1'b1);
      wr(4'h6, v);
      if (i == 3) begin
        idle(10);
        rd(4'h1, v); chk("R10 still pending", v[2], 1'b1);
      end
    end
    drain();
    rd(4'h1, v); chk("R10 done clears", v[2], 1'b0);
    rd(4'h2, v); chk("R10 done irq", v[4], 1'b1);
    rd(4'hB, v); chk("R12 write xor", v, x);

    // R11 page read, both bits written
    wr(4'h9, 8'h01); idle(6);
    wr(4'h2, 8'h1F);
    k0 = rd_idx;
    rd(4'h8, v);
    wr(4'hA, 8'h03);
    rd(4'h1, x); chk("R12 read wins", {x[3], x[2]}, 2'b10);
    idle(80);
    rd(4'h1, x); chk("R11 done clears", x[3], 1'b0);
    chk("R11 read count", rd_idx - k0, 8);
    x = 8'h00;
    for (int i = 1; i <= 8; i++) x = x ^ pat(k0 + i);
    rd(4'hB, bus_wdata);
    chk("R12 read xor", bus_wdata, x);
    rd(4'h2, x); chk("R11 no rd ready", x[3], 1'b0);
    rd(4'h8, x); chk("R11 read reg kept", x, v);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule